// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Fractional Stop Timing

This block turns parallel characters into an asynchronous serial line. A character is offered on a valid/ready handshake together with its framing settings: character length, parity mode, stop length and clock factor. The block sends a low start bit, the data bits least significant first, an optional parity bit and a high stop period. All timing is counted in clock enables that arrive on `tick_i` at the oversampled rate. A bit lasts as many ticks as the clock factor. The stop period is set in sixteenths of a bit, so stop lengths such as 11/16 or 27/16 of a bit are possible.

A break command holds the line low for as long as it stays asserted. It takes effect only between characters: a character already in flight finishes, stop period included, before the line is pulled low. The framing settings are captured when a character is accepted. Changes on those inputs during the character have no effect on it.

Top module: `async_frac_tx`

## Requirements
- R1: After reset and whenever no character or break is in progress, `tx_o` is 1, `busy_o` is 0 and `ready_o` is 1 (provided `brk_i` is 0).
- R2: A character is accepted on the clock edge where `valid_i` and `ready_o` are both 1. From the next cycle until its stop period completes, `ready_o` is 0, `busy_o` is 1, and `valid_i` has no effect.
- R3: The frame starts with one low start bit, followed by `char_len_i`+1 data bits sent least significant bit first. Each bit lasts F ticks, where `factor_i` 0 gives F=16, 1 gives F=32, and 2 or 3 give F=64.
- R4: `parity_i` selects the parity bit sent after the data bits: 1 is odd (total ones in the data bits plus parity is odd), 2 is even, 3 is always 1, 4 is always 0, and 0, 5, 6 and 7 send no parity bit. Parity covers only the transmitted data bits.
- R5: The stop period is high for (`stop_i`+1)·F/16 ticks, giving 1/16 to 32/16 of a bit. `ready_o` is 1 and `busy_o` is 0 in the cycle after the edge that consumes the last stop tick.
- R6: `data_i`, `char_len_i`, `parity_i`, `stop_i` and `factor_i` are captured at acceptance. Changing them while a character is in flight does not alter that character.
- R7: With the line idle, asserting `brk_i` drops `ready_o` in the same cycle and drives `tx_o` low with `busy_o` 1 from the next cycle. One cycle after `brk_i` is released, the line is high and `ready_o` is 1.
- R8: If `brk_i` is asserted during a character, the character completes unchanged. The line goes low in the cycle right after the last stop tick, with no idle-high gap.
- R9: During a character, `tx_o` changes only on clock edges where `tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampled clock enable |
| valid_i | input | 1 | Character offered |
| ready_o | output | 1 | Character can be accepted |
| data_i | input | 8 | Character bits, LSB sent first |
| char_len_i | input | 3 | Data bit count minus one |
| parity_i | input | 3 | Parity mode code |
| stop_i | input | 5 | Stop length in sixteenths of a bit, minus one |
| factor_i | input | 2 | Clock factor code (16/32/64) |
| brk_i | input | 1 | Break command |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | Character or break in progress |

## Verification
The line falls in the cycle after the acceptance edge. Each later segment ends on the rising edge that carries its last counted tick, and the new level is visible in the cycle after that edge. `ready_o` returns in the same cycle that the stop period ends. A break taken from idle shows on the line one cycle after `brk_i` rises and clears one cycle after it falls. The bench drives `tick_i` itself and counts the ticks seen at each rising edge. It samples every output at the falling edge that follows, so each segment is compared against its expected level for exactly its programmed tick count.

// File: rtl/atx_pkg.sv
package atx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4,
    ST_BRK   = 3'd5
  } atx_state_e;

  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  // ticks per bit = 16 << shift
  function automatic logic [1:0] factor_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/atx_parity.sv
module atx_parity #(
  parameter int MAX_BITS = 8,
  parameter int LEN_W    = $clog2(MAX_BITS)
) (
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [LEN_W-1:0]    len_m1_i,
  input  logic [2:0]          mode_i,
  output logic                par_en_o,
  output logic                par_bit_o
);
  logic [MAX_BITS-1:0] masked;
  logic                ones_odd;

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign masked[i] = data_i[i] & (len_m1_i >= LEN_W'(i));
  end

  assign ones_odd = ^masked;

  always_comb begin
    par_en_o  = 1'b1;
    par_bit_o = 1'b0;
    case (mode_i)
      atx_pkg::PAR_ODD:   par_bit_o = ~ones_odd;
      atx_pkg::PAR_EVEN:  par_bit_o = ones_odd;
      atx_pkg::PAR_MARK:  par_bit_o = 1'b1;
      atx_pkg::PAR_SPACE: par_bit_o = 1'b0;
      default:            par_en_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/atx_timer.sv
module atx_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= done_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/atx_seq.sv
module atx_seq
  import atx_pkg::*;
#(
  parameter int MAX_BITS = 8,
  parameter int LEN_W    = $clog2(MAX_BITS),
  parameter int STOP_W   = 5,
  parameter int CNT_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [LEN_W-1:0]    len_m1_i,
  input  logic [STOP_W-1:0]   stop_i,
  input  logic [1:0]          factor_i,
  input  logic                par_en_i,
  input  logic                par_bit_i,
  input  logic                brk_i,
  input  logic                seg_done_i,
  output logic                ready_o,
  output logic                busy_o,
  output logic                tx_o,
  output logic                run_o,
  output logic [CNT_W-1:0]    limit_o,
  output atx_state_e          state_o
);
  atx_state_e          state_q;
  logic [MAX_BITS-1:0] sh_q;
  logic [LEN_W-1:0]    len_q, bit_q;
  logic [STOP_W-1:0]   stop_q;
  logic [1:0]          fsh_q;
  logic                pen_q, pbit_q;
  logic [CNT_W-1:0]    bit_ticks, stop_ticks;

  assign bit_ticks  = CNT_W'(16) << fsh_q;
  assign stop_ticks = (CNT_W'(stop_q) + CNT_W'(1)) << fsh_q;
  assign limit_o    = (state_q == ST_STOP) ? stop_ticks : bit_ticks;

  assign run_o   = (state_q != ST_IDLE) && (state_q != ST_BRK);
  assign busy_o  = (state_q != ST_IDLE);
  assign ready_o = (state_q == ST_IDLE) && !brk_i;
  assign state_o = state_q;

  always_comb begin
    case (state_q)
      ST_START, ST_BRK: tx_o = 1'b0;
      ST_DATA:          tx_o = sh_q[0];
      ST_PAR:           tx_o = pbit_q;
      default:          tx_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      len_q   <= '0;
      bit_q   <= '0;
      stop_q  <= '0;
      fsh_q   <= '0;
      pen_q   <= 1'b0;
      pbit_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (brk_i) begin
            state_q <= ST_BRK;
          end else if (valid_i) begin
            state_q <= ST_START;
            sh_q    <= data_i;
            len_q   <= len_m1_i;
            stop_q  <= stop_i;
            fsh_q   <= factor_shift(factor_i);
            pen_q   <= par_en_i;
            pbit_q  <= par_bit_i;
          end
        end
        ST_START: begin
          if (seg_done_i) begin
            state_q <= ST_DATA;
            bit_q   <= '0;
          end
        end
        ST_DATA: begin
          if (seg_done_i) begin
            sh_q <= sh_q >> 1;
            if (bit_q == len_q) state_q <= pen_q ? ST_PAR : ST_STOP;
            else                bit_q   <= bit_q + LEN_W'(1);
          end
        end
        ST_PAR: begin
          if (seg_done_i) state_q <= ST_STOP;
        end
        ST_STOP: begin
          // break waits for the character boundary
          if (seg_done_i) state_q <= brk_i ? ST_BRK : ST_IDLE;
        end
        ST_BRK: begin
          if (!brk_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_frac_tx.sv
module async_frac_tx #(
  parameter int MAX_BITS  = 8,
  parameter int STOP_W    = 5,
  parameter int MAX_SHIFT = 2,
  localparam int LEN_W    = $clog2(MAX_BITS),
  localparam int CNT_W    = $clog2((2**STOP_W) * (2**MAX_SHIFT) + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                valid_i,
  output logic                ready_o,
  input  logic [MAX_BITS-1:0] data_i,
  input  logic [LEN_W-1:0]    char_len_i,
  input  logic [2:0]          parity_i,
  input  logic [STOP_W-1:0]   stop_i,
  input  logic [1:0]          factor_i,
  input  logic                brk_i,
  output logic                tx_o,
  output logic                busy_o
);
  logic                 par_en, par_bit, seg_done, run;
  logic [CNT_W-1:0]     limit;
  atx_pkg::atx_state_e  state;

  atx_parity #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) i_parity (
    .data_i    (data_i),
    .len_m1_i  (char_len_i),
    .mode_i    (parity_i),
    .par_en_o  (par_en),
    .par_bit_o (par_bit)
  );

  atx_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .tick_i  (tick_i),
    .limit_i (limit),
    .done_o  (seg_done)
  );

  atx_seq #(
    .MAX_BITS (MAX_BITS),
    .LEN_W    (LEN_W),
    .STOP_W   (STOP_W),
    .CNT_W    (CNT_W)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .data_i     (data_i),
    .len_m1_i   (char_len_i),
    .stop_i     (stop_i),
    .factor_i   (factor_i),
    .par_en_i   (par_en),
    .par_bit_i  (par_bit),
    .brk_i      (brk_i),
    .seg_done_i (seg_done),
    .ready_o    (ready_o),
    .busy_o     (busy_o),
    .tx_o       (tx_o),
    .run_o      (run),
    .limit_o    (limit),
    .state_o    (state)
  );
endmodule

// File: rtl/atx_checker.sv
module atx_checker (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic                valid_i,
  input logic                brk_i,
  input logic                ready_o,
  input logic                busy_o,
  input logic                tx_o,
  input atx_pkg::atx_state_e state_i
);
  a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  a_r2_ready_only_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!busy_o && !brk_i));

  a_r3_accept_starts_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (busy_o && !tx_o));

  a_r7_break_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !busy_o) |=> (busy_o && !tx_o));

  a_r9_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i && state_i != atx_pkg::ST_BRK) |=> ($stable(tx_o) && busy_o));
endmodule

bind async_frac_tx atx_checker i_atx_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .valid_i (valid_i),
  .brk_i   (brk_i),
  .ready_o (ready_o),
  .busy_o  (busy_o),
  .tx_o    (tx_o),
  .state_i (state)
);

// File: tb/test_async_frac_tx.sv
module test_async_frac_tx;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       tick_i, valid_i, brk_i;
  logic [7:0] data_i;
  logic [2:0] char_len_i, parity_i;
  logic [4:0] stop_i;
  logic [1:0] factor_i;
  logic       ready_o, tx_o, busy_o;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  async_frac_tx i_async_frac_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .valid_i(valid_i),
    .ready_o(ready_o), .data_i(data_i), .char_len_i(char_len_i),
    .parity_i(parity_i), .stop_i(stop_i), .factor_i(factor_i),
    .brk_i(brk_i), .tx_o(tx_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ticks_per_bit(input int code);
    return (code == 0) ? 16 : (code == 1) ? 32 : 64;
  endfunction

  // -1: no parity bit
  function automatic int exp_parity(input logic [7:0] d, input int nbits, input int mode);
    int ones = 0;
    for (int i = 0; i < nbits; i++) ones += int'(d[i]);
    case (mode)
      1: return (ones % 2 == 0) ? 1 : 0;
      2: return ones % 2;
      3: return 1;
      4: return 0;
      default: return -1;
    endcase
  endfunction

  task automatic randomize_side_inputs();
    data_i     = 8'($urandom);
    char_len_i = 3'($urandom);
    parity_i   = 3'($urandom);
    stop_i     = 5'($urandom);
    factor_i   = 2'($urandom);
  endtask

  task automatic send_frame(input logic [7:0] d, input int len_m1, input int mode,
                            input int stop, input int fac, input bit mid_brk,
                            input int pct);
    int lvl[12];
    int dur[12];
    string tag[12];
    int nseg = 0;
    int f = ticks_per_bit(fac);
    int p = exp_parity(d, len_m1 + 1, mode);
    int total_bad = 0;

    @(negedge clk_i);
    check(ready_o === 1'b1 && busy_o === 1'b0, "R1 ready before frame", int'(ready_o), 1);
    valid_i = 1'b1; tick_i = 1'b0; data_i = d;
    char_len_i = 3'(len_m1); parity_i = 3'(mode); stop_i = 5'(stop); factor_i = 2'(fac);
    @(posedge clk_i);
    @(negedge clk_i);

    lvl[nseg] = 0; dur[nseg] = f; tag[nseg] = "R3 start bit"; nseg++;
    for (int i = 0; i <= len_m1; i++) begin
      lvl[nseg] = int'(d[i]); dur[nseg] = f; tag[nseg] = "R3 data bit"; nseg++;
    end
    if (p >= 0) begin
      lvl[nseg] = p; dur[nseg] = f; tag[nseg] = "R4 parity bit"; nseg++;
    end
    lvl[nseg] = 1; dur[nseg] = (stop + 1) * f / 16; tag[nseg] = "R5 stop period"; nseg++;

    for (int s = 0; s < nseg; s++) begin
      int cnt = 0;
      int bad = 0;
      int act = lvl[s];
      while (cnt < dur[s]) begin
        if (tx_o !== 1'(lvl[s]) || ready_o !== 1'b0 || busy_o !== 1'b1) begin
          bad++;
          act = int'(tx_o);
        end
        tick_i  = (($urandom % 100) < pct);
        valid_i = 1'($urandom);
        randomize_side_inputs();
        if (mid_brk && s == nseg / 2) brk_i = 1'b1;
        @(posedge clk_i);
        if (tick_i) cnt++;
        @(negedge clk_i);
      end
      total_bad += bad;
      check(bad == 0, tag[s], act, lvl[s]);
    end
    check(total_bad == 0, "R2 R6 R9 frame unaffected by in-flight inputs", total_bad, 0);

    valid_i = 1'b0; tick_i = 1'b0;
    #1;
    if (mid_brk) begin
      check(tx_o === 1'b0 && busy_o === 1'b1 && ready_o === 1'b0,
            "R8 break follows stop without gap", int'(tx_o), 0);
      brk_i = 1'b0;
      @(posedge clk_i);
      @(negedge clk_i);
      check(tx_o === 1'b1 && ready_o === 1'b1, "R7 release after break", int'(tx_o), 1);
    end else begin
      check(tx_o === 1'b1 && ready_o === 1'b1 && busy_o === 1'b0,
            "R5 ready right after stop", int'(ready_o), 1);
    end
  endtask

  task automatic idle_break(input int hold);
    int bad = 0;
    @(negedge clk_i);
    brk_i = 1'b1; tick_i = 1'b0;
    #1;
    check(ready_o === 1'b0, "R7 ready drops with break", int'(ready_o), 0);
    @(posedge clk_i);
    @(negedge clk_i);
    check(tx_o === 1'b0 && busy_o === 1'b1, "R7 line low on break", int'(tx_o), 0);
    for (int i = 0; i < hold; i++) begin
      valid_i = 1'b1;
      tick_i  = 1'($urandom);
      @(posedge clk_i);
      @(negedge clk_i);
      if (tx_o !== 1'b0 || ready_o !== 1'b0) bad++;
    end
    check(bad == 0, "R2 R7 break holds, valid ignored", bad, 0);
    valid_i = 1'b0; brk_i = 1'b0; tick_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tx_o === 1'b1 && ready_o === 1'b1 && busy_o === 1'b0,
          "R7 idle after break release", int'(tx_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_a11c));
    rst_ni = 1'b0; tick_i = 1'b0; valid_i = 1'b0; brk_i = 1'b0;
    data_i = '0; char_len_i = '0; parity_i = '0; stop_i = '0; factor_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(tx_o === 1'b1 && busy_o === 1'b0 && ready_o === 1'b1, "R1 reset state", int'(tx_o), 1);
    rst_ni = 1'b1;

    // directed corners
    send_frame(8'hA5, 7, 0, 15, 0, 1'b0, 100);  // 8 bits, no parity, 1 stop bit
    send_frame(8'h01, 0, 1, 0, 0, 1'b0, 100);   // 1 bit, odd, 1/16 stop
    send_frame(8'h7E, 7, 2, 31, 1, 1'b0, 60);   // even, 2 stops, factor 32
    send_frame(8'h3C, 5, 3, 10, 2, 1'b0, 70);   // mark, 11/16 stop, factor 64
    send_frame(8'hFF, 6, 4, 23, 3, 1'b0, 80);   // space, code 3 -> 64
    send_frame(8'h00, 4, 1, 7, 0, 1'b0, 50);    // odd parity of all zeros
    send_frame(8'h96, 7, 6, 3, 1, 1'b0, 90);    // reserved parity code
    idle_break(20);
    send_frame(8'h5A, 3, 2, 5, 0, 1'b1, 100);   // break during char

    for (int k = 0; k < 20; k++) begin
      send_frame(8'($urandom), int'($urandom % 8), int'($urandom % 8),
                 int'($urandom % 32), int'($urandom % 4), 1'($urandom % 4 == 0),
                 50 + int'($urandom % 51));
      if ($urandom % 3 == 0) idle_break(1 + int'($urandom % 10));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule